// File: doc/BRIEF.md
# Station Search and Digital AFT Controller

This block owns the tuning counter of a voltage-synthesis tuner. On a search request it sweeps the counter upward through the current band. Two comparator inputs report where the receiver sits on the discriminator curve, and the block uses them to slow the sweep in stages until the station is centred. It then holds that station with a closed correction loop. The correction loop moves up faster than it moves down.

When a sweep reaches the top of a band without finding a station, the block pauses. It then continues from the bottom of the next enabled band. A value recalled from storage is loaded through a valid/ready port. When the correction loop is enabled, the recalled value is loaded slightly low so that the loop pulls it up onto the station.

Recall is the only data transfer. It completes in the cycle where `recall_valid` and `recall_ready` are both high. `recall_ready` is low during reset and high from the first cycle after reset. No back-pressure is applied after that point, and a recall is accepted in every state.

All speeds are counted in base ticks. One base tick lasts `BASE_DIV` clock cycles.

Top module: `station_tuner`

## Requirements
- R1: During and after reset, `tune_value` is 0, `band_sel` is 0, and `search_active` and `locked` are 0. `recall_ready` is 0 during reset and becomes 1 in the first cycle after reset.
- R2: The input pair (`aft_up_in`, `aft_dn_in`) is decoded as follows: 1,0 requests up; 0,1 requests down; 0,0 means centred; 1,1 means no operation. Centred and no-operation cause no motion and no change of stage.
- R3: A `search_start` pulse begins a fast upward sweep from the present counter value. The fast step period is 1 base tick in bands 0 and 2 (the two VHF bands) and 4 base ticks in bands 1 (CATV) and 3 (UHF).
- R4: During a sweep, the AFT inputs are ignored for the first 60 steps in bands 0 and 2, and for the first 15 steps in bands 1 and 3.
- R5: After the blanking steps, an up request moves the fast sweep to a medium-up sweep at twice the fast period. A down request during the fast sweep is ignored.
- R6: A down request during the medium-up sweep starts a medium-down sweep. This sweep decrements the counter at four times the fast period.
- R7: An up request during the medium-down sweep ends the search. `search_active` falls and `locked` rises.
- R8: While locked with `aft_en` high, an up request increments the counter every 16 base ticks and a down request decrements it every 128 base ticks. Centred and no-operation hold the counter. With `aft_en` low, the counter does not move and `locked` is 0.
- R9: In the locked state, the counter saturates at 0 and at its maximum value and never wraps.
- R10: A sweep step at the maximum value holds the counter there for `PAUSE_TICKS` base ticks. The sweep then restarts a fast sweep, with blanking, from 0 in the next enabled band. Bands are tried in the order 0, 1, 2, 3 and back to 0, and `band_enable[i]` enables band i. If no band is enabled, the band stays as it is.
- R11: An accepted recall aborts any search and loads `recall_band` into `band_sel`. With `aft_en` high, it loads `recall_value` minus 8 (saturating at 0) and enters the locked state. With `aft_en` low, it loads `recall_value` unchanged and stays idle.
- R12: While `mute` is high, the AFT inputs are treated as no-operation. A sweep continues at its present speed, and a locked counter holds.
- R13: Outside recall and band restart, the counter changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_start | input | 1 | One-cycle request to begin an upward search |
| aft_en | input | 1 | Enables the closed correction loop |
| aft_up_in | input | 1 | First comparator input |
| aft_dn_in | input | 1 | Second comparator input |
| mute | input | 1 | Forces the comparator inputs to be ignored |
| band_enable | input | 4 | Per-band enable, bit i for band i |
| recall_valid | input | 1 | A recalled setting is offered |
| recall_ready | output | 1 | The block accepts a recalled setting |
| recall_value | input | CNT_W | Recalled tuning value |
| recall_band | input | 2 | Recalled band |
| tune_value | output | CNT_W | Tuning counter |
| band_sel | output | 2 | Selected band |
| search_active | output | 1 | A sweep or an inter-band pause is running |
| locked | output | 1 | The correction loop is holding a station |

## Verification
A recall or search request registers on the next edge, so the bench checks its effect at the falling edge after the request. Sweep speeds are checked as the number of cycles between successive changes of `tune_value`, which equals the step period in base ticks times `BASE_DIV`. The first interval after any change of stage is partial and is discarded. Blanking is measured by the counter value at the first interval longer than the fast period, which must equal the blanking count. Holds and saturation are checked by watching the counter stay constant over windows longer than the slowest step period.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FAST,
    ST_MED_UP,
    ST_MED_DN,
    ST_LOCK,
    ST_PAUSE
  } tstate_t;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DN   = 2'd2
  } aft_cmd_t;

  // Band codes follow the step-by-step order
  localparam logic [1:0] BAND_VHF1 = 2'd0;
  localparam logic [1:0] BAND_CATV = 2'd1;
  localparam logic [1:0] BAND_VHF3 = 2'd2;
  localparam logic [1:0] BAND_UHF  = 2'd3;

  function automatic logic band_is_vhf(input logic [1:0] b);
    return (b == BAND_VHF1) || (b == BAND_VHF3);
  endfunction

endpackage

// File: rtl/aft_decode.sv
module aft_decode
  import tune_pkg::*;
(
  input  logic     up_in,
  input  logic     dn_in,
  input  logic     mute,
  output aft_cmd_t cmd
);

  always_comb begin
    cmd = CMD_HOLD;
    if (!mute) begin
      if (up_in && !dn_in)      cmd = CMD_UP;
      else if (!up_in && dn_in) cmd = CMD_DN;
    end
  end

endmodule

// File: rtl/band_picker.sv
module band_picker #(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic [BW-1:0] cur,
  input  logic [NB-1:0] en,
  output logic [BW-1:0] nxt
);

  // Scan from farthest to nearest so the nearest enabled band wins
  always_comb begin
    nxt = cur;
    for (int k = NB; k >= 1; k--) begin
      if (en[BW'((int'(cur) + k) % NB)]) nxt = BW'((int'(cur) + k) % NB);
    end
  end

  always_comb begin
    if (|en) begin
      a_r10_pick_enabled: assert (en[nxt]);
    end
  end

endmodule

// File: rtl/rate_timer.sv
module rate_timer #(
  parameter int BASE_DIV = 488,
  parameter int PER_W    = 9,
  localparam int BD_W    = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             step
);

  logic [BD_W-1:0]  base_cnt;
  logic [PER_W-1:0] div_cnt;
  logic             base_tick;

  assign base_tick = (base_cnt == BD_W'(BASE_DIV - 1));
  assign step      = !restart && base_tick && (div_cnt == period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      base_cnt <= '0;
      div_cnt  <= '0;
    end else begin
      base_cnt <= base_tick ? '0 : base_cnt + BD_W'(1);
      if (base_tick) begin
        div_cnt <= (div_cnt == period - PER_W'(1)) ? '0 : div_cnt + PER_W'(1);
      end
    end
  end

  // R3: the divider never runs past the period it serves
  a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (div_cnt < period));

endmodule

// File: rtl/station_tuner.sv
module station_tuner
  import tune_pkg::*;
#(
  parameter int CNT_W         = 13,
  parameter int BASE_DIV      = 488,
  parameter int FAST_VHF_PER  = 1,
  parameter int FAST_HI_PER   = 4,
  parameter int SLOW_UP_PER   = 16,
  parameter int VSLOW_DN_PER  = 128,
  parameter int PAUSE_TICKS   = 492,
  parameter int BLANK_VHF     = 60,
  parameter int BLANK_HI      = 15,
  parameter int RECALL_OFFSET = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_start,
  input  logic             aft_en,
  input  logic             aft_up_in,
  input  logic             aft_dn_in,
  input  logic             mute,
  input  logic [3:0]       band_enable,
  input  logic             recall_valid,
  output logic             recall_ready,
  input  logic [CNT_W-1:0] recall_value,
  input  logic [1:0]       recall_band,
  output logic [CNT_W-1:0] tune_value,
  output logic [1:0]       band_sel,
  output logic             search_active,
  output logic             locked
);

  localparam logic [CNT_W-1:0] VMAX = {CNT_W{1'b1}};
  localparam int FAST_MAX = (FAST_HI_PER > FAST_VHF_PER) ? FAST_HI_PER : FAST_VHF_PER;
  localparam int P_A      = (PAUSE_TICKS > VSLOW_DN_PER) ? PAUSE_TICKS : VSLOW_DN_PER;
  localparam int P_B      = (4 * FAST_MAX > SLOW_UP_PER) ? 4 * FAST_MAX : SLOW_UP_PER;
  localparam int PER_MAX  = (P_A > P_B) ? P_A : P_B;
  localparam int PER_W    = $clog2(PER_MAX + 1);
  localparam int BLK_MAX  = (BLANK_VHF > BLANK_HI) ? BLANK_VHF : BLANK_HI;
  localparam int BLK_W    = $clog2(BLK_MAX + 1);

  tstate_t          st_q, st_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic [1:0]       band_q, band_d, band_nxt;
  logic [BLK_W-1:0] blank_q, blank_d, blank_lim;
  logic             ready_q;
  logic             recall_fire;
  logic             blank_done;
  logic             step, restart;
  aft_cmd_t         cmd, lock_cmd;
  logic [PER_W-1:0] fast_per, period;
  logic [4:0]       key_d, key_q;

  aft_decode u_decode (
    .up_in (aft_up_in),
    .dn_in (aft_dn_in),
    .mute  (mute),
    .cmd   (cmd)
  );

  band_picker #(.NB(4)) u_pick (
    .cur (band_q),
    .en  (band_enable),
    .nxt (band_nxt)
  );

  rate_timer #(.BASE_DIV(BASE_DIV), .PER_W(PER_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .period  (period),
    .step    (step)
  );

  assign recall_fire = recall_valid && ready_q;
  assign blank_lim   = band_is_vhf(band_q) ? BLK_W'(BLANK_VHF) : BLK_W'(BLANK_HI);
  assign blank_done  = (blank_q >= blank_lim);
  assign fast_per    = band_is_vhf(band_q) ? PER_W'(FAST_VHF_PER) : PER_W'(FAST_HI_PER);
  assign lock_cmd    = (st_q == ST_LOCK && aft_en) ? cmd : CMD_HOLD;

  // Step period for the present stage, in base ticks
  always_comb begin
    unique case (st_q)
      ST_FAST:   period = fast_per;
      ST_MED_UP: period = fast_per << 1;
      ST_MED_DN: period = fast_per << 2;
      ST_LOCK:   period = (lock_cmd == CMD_DN) ? PER_W'(VSLOW_DN_PER) : PER_W'(SLOW_UP_PER);
      ST_PAUSE:  period = PER_W'(PAUSE_TICKS);
      default:   period = PER_W'(1);
    endcase
  end

  // Any change of stage or lock direction restarts the step timer
  assign key_d   = {st_q, lock_cmd};
  assign restart = (key_d != key_q);

  always_comb begin
    st_d    = st_q;
    val_d   = val_q;
    band_d  = band_q;
    blank_d = blank_q;
    if (recall_fire) begin
      band_d = recall_band;
      if (aft_en) begin
        val_d = (recall_value < CNT_W'(RECALL_OFFSET)) ? '0 : recall_value - CNT_W'(RECALL_OFFSET);
        st_d  = ST_LOCK;
      end else begin
        val_d = recall_value;
        st_d  = ST_IDLE;
      end
    end else if (search_start) begin
      st_d    = ST_FAST;
      blank_d = '0;
    end else begin
      unique case (st_q)
        ST_FAST: begin
          if (step) begin
            if (val_q == VMAX) st_d = ST_PAUSE;
            else begin
              val_d = val_q + CNT_W'(1);
              if (!blank_done) blank_d = blank_q + BLK_W'(1);
            end
          end
          if (st_d == ST_FAST && blank_done && cmd == CMD_UP) st_d = ST_MED_UP;
        end
        ST_MED_UP: begin
          if (step) begin
            if (val_q == VMAX) st_d = ST_PAUSE;
            else val_d = val_q + CNT_W'(1);
          end
          if (st_d == ST_MED_UP && cmd == CMD_DN) st_d = ST_MED_DN;
        end
        ST_MED_DN: begin
          if (step && val_q != '0) val_d = val_q - CNT_W'(1);
          if (cmd == CMD_UP) st_d = ST_LOCK;
        end
        ST_LOCK: begin
          if (step && lock_cmd == CMD_UP && val_q != VMAX) val_d = val_q + CNT_W'(1);
          if (step && lock_cmd == CMD_DN && val_q != '0)   val_d = val_q - CNT_W'(1);
        end
        ST_PAUSE: begin
          if (step) begin
            band_d  = band_nxt;
            val_d   = '0;
            blank_d = '0;
            st_d    = ST_FAST;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      val_q   <= '0;
      band_q  <= BAND_VHF1;
      blank_q <= '0;
      key_q   <= {ST_IDLE, CMD_HOLD};
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      val_q   <= val_d;
      band_q  <= band_d;
      blank_q <= blank_d;
      key_q   <= key_d;
      ready_q <= 1'b1;
    end
  end

  assign recall_ready  = ready_q;
  assign tune_value    = val_q;
  assign band_sel      = band_q;
  assign search_active = (st_q == ST_FAST) || (st_q == ST_MED_UP) ||
                         (st_q == ST_MED_DN) || (st_q == ST_PAUSE);
  assign locked        = (st_q == ST_LOCK) && aft_en;

  // R13: single-step motion outside recall and band restart
  a_r13_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(recall_fire) && $past(st_q) != ST_PAUSE) |->
      (val_q == $past(val_q) ||
       {1'b0, val_q} == {1'b0, $past(val_q)} + (CNT_W+1)'(1) ||
       {1'b0, $past(val_q)} == {1'b0, val_q} + (CNT_W+1)'(1)));

  // R4: no leaving the fast sweep while blanking
  a_r4_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAST && !blank_done && !search_start && !recall_fire) |=> st_q != ST_MED_UP);

  // R6: medium-down is entered only from medium-up
  a_r6_med_dn_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MED_DN && $past(st_q) != ST_MED_DN) |-> $past(st_q) == ST_MED_UP);

  // R9: the locked counter never wraps
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && $past(st_q) == ST_LOCK && !$past(recall_fire)) |->
      !((val_q == VMAX && $past(val_q) == '0) || (val_q == '0 && $past(val_q) == VMAX)));

  // R10: the inter-band pause holds the top value
  a_r10_pause_top: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAUSE) |-> val_q == VMAX);

  // R12: muted lock holds still
  a_r12_mute_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && mute && !recall_fire && !search_start) |=> val_q == $past(val_q));

endmodule

// File: tb/test_station_tuner.sv
module test_station_tuner;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         search_start = 1'b0;
  logic         aft_en = 1'b1;
  logic         aft_up_in = 1'b1;
  logic         aft_dn_in = 1'b1;
  logic         mute = 1'b0;
  logic [3:0]   band_enable = 4'hF;
  logic         recall_valid = 1'b0;
  logic         recall_ready;
  logic [W-1:0] recall_value = '0;
  logic [1:0]   recall_band = '0;
  logic [W-1:0] tune_value;
  logic [1:0]   band_sel;
  logic         search_active;
  logic         locked;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  station_tuner #(
    .CNT_W(W), .BASE_DIV(2), .PAUSE_TICKS(20)
  ) i_station_tuner (
    .clk(clk), .rst_n(rst_n), .search_start(search_start), .aft_en(aft_en),
    .aft_up_in(aft_up_in), .aft_dn_in(aft_dn_in), .mute(mute),
    .band_enable(band_enable), .recall_valid(recall_valid),
    .recall_ready(recall_ready), .recall_value(recall_value),
    .recall_band(recall_band), .tune_value(tune_value), .band_sel(band_sel),
    .search_active(search_active), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_aft(input logic a, input logic b);
    aft_up_in = a;
    aft_dn_in = b;
  endtask

  task automatic do_recall(input int v, input int b, input logic en);
    aft_en = en;
    recall_value = W'(v);
    recall_band = 2'(b);
    recall_valid = 1'b1;
    @(negedge clk);
    recall_valid = 1'b0;
  endtask

  task automatic start_search();
    search_start = 1'b1;
    @(negedge clk);
    search_start = 1'b0;
  endtask

  task automatic measure_gap(output int gap);
    logic [W-1:0] v0;
    v0 = tune_value;
    gap = 0;
    while (tune_value == v0 && gap < 3000) begin
      @(negedge clk);
      gap++;
    end
  endtask

  task automatic hold_window(input int cycles, input string req);
    logic [W-1:0] v0;
    bit moved;
    v0 = tune_value;
    moved = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tune_value != v0) moved = 1'b1;
    end
    check(!moved, req, int'(tune_value), int'(v0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tune_value == 0 && band_sel == 0, "R1 reset value/band", int'(tune_value), 0);
    check(!search_active && !locked, "R1 reset flags", int'({search_active, locked}), 0);
    check(recall_ready == 1'b0, "R1 ready low in reset", int'(recall_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(recall_ready == 1'b1, "R1 ready after reset", int'(recall_ready), 1);
    check(tune_value == 0, "R1 value after reset", int'(tune_value), 0);
  endtask

  task automatic t_recall();
    set_aft(1, 1);
    do_recall(100, 2, 1);
    check(tune_value == 92, "R11 recall minus offset", int'(tune_value), 92);
    check(band_sel == 2, "R11 recall band", int'(band_sel), 2);
    check(locked && !search_active, "R11 recall locks", int'({locked, search_active}), 2);
    do_recall(5, 1, 1);
    check(tune_value == 0, "R11 offset saturates", int'(tune_value), 0);
    do_recall(77, 3, 0);
    check(tune_value == 77 && !locked, "R11 recall unchanged without AFT", int'(tune_value), 77);
  endtask

  task automatic t_fast_rates();
    int gap;
    set_aft(1, 1);
    do_recall(40, 0, 0);
    aft_en = 1'b1;
    start_search();
    check(search_active == 1'b1, "R3 search active", int'(search_active), 1);
    measure_gap(gap);
    check(tune_value == 41, "R3 starts from current value", int'(tune_value), 41);
    for (int i = 0; i < 3; i++) begin
      measure_gap(gap);
      check(gap == 2, "R3 fast VHF period", gap, 2);
    end
    while (tune_value < 120) measure_gap(gap);
    measure_gap(gap);
    check(gap == 2, "R2 no-operation leaves fast sweep", gap, 2);
    do_recall(0, 3, 0);
    check(!search_active && tune_value == 0, "R11 recall aborts search", int'(search_active), 0);
    start_search();
    measure_gap(gap);
    for (int i = 0; i < 2; i++) begin
      measure_gap(gap);
      check(gap == 8, "R3 fast UHF period", gap, 8);
    end
  endtask

  task automatic t_uhf_down_ignored();
    int gap;
    set_aft(0, 1);
    do_recall(0, 3, 0);
    aft_en = 1'b1;
    start_search();
    while (tune_value < 25) measure_gap(gap);
    measure_gap(gap);
    check(gap == 8, "R5 down ignored in fast sweep", gap, 8);
    set_aft(1, 0);
    measure_gap(gap);
    measure_gap(gap);
    check(gap == 16, "R5 UHF medium-up period", gap, 16);
  endtask

  task automatic t_approach();
    int gap;
    int prev;
    int v_before;
    set_aft(1, 0);
    do_recall(0, 0, 0);
    aft_en = 1'b1;
    start_search();
    measure_gap(gap);
    v_before = -1;
    for (int i = 0; i < 100 && v_before < 0; i++) begin
      prev = int'(tune_value);
      measure_gap(gap);
      if (gap > 2) v_before = prev;
    end
    check(v_before == 60, "R4 VHF blanking length", v_before, 60);
    measure_gap(gap);
    check(gap == 4, "R5 medium-up period", gap, 4);
    set_aft(0, 1);
    measure_gap(gap);
    prev = int'(tune_value);
    measure_gap(gap);
    check(gap == 8, "R6 medium-down period", gap, 8);
    check(int'(tune_value) == prev - 1, "R6 medium-down direction", int'(tune_value), prev - 1);
    set_aft(1, 0);
    @(negedge clk);
    @(negedge clk);
    check(locked && !search_active, "R7 lock after up", int'({locked, search_active}), 2);
    measure_gap(gap);
    prev = int'(tune_value);
    measure_gap(gap);
    check(gap == 32 && int'(tune_value) == prev + 1, "R8 slow up rate", gap, 32);
    set_aft(0, 1);
    measure_gap(gap);
    prev = int'(tune_value);
    measure_gap(gap);
    check(gap == 256 && int'(tune_value) == prev - 1, "R8 very slow down rate", gap, 256);
    set_aft(0, 0);
    hold_window(600, "R8 centred holds");
    set_aft(1, 1);
    hold_window(300, "R2 no-operation holds in lock");
    set_aft(1, 0);
    aft_en = 1'b0;
    @(negedge clk);
    check(!locked, "R8 locked low without AFT", int'(locked), 0);
    hold_window(200, "R8 no motion without AFT");
    aft_en = 1'b1;
  endtask

  task automatic t_saturate();
    set_aft(1, 1);
    do_recall(5, 0, 1);
    set_aft(0, 1);
    repeat (1000) @(negedge clk);
    check(tune_value == 0, "R9 saturate at zero", int'(tune_value), 0);
    set_aft(1, 1);
    do_recall(250, 0, 1);
    check(tune_value == 242, "R11 recall minus offset high", int'(tune_value), 242);
    set_aft(1, 0);
    repeat (600) @(negedge clk);
    check(tune_value == 255, "R9 saturate at top", int'(tune_value), 255);
  endtask

  task automatic t_mute();
    int gap;
    set_aft(1, 1);
    do_recall(100, 0, 1);
    set_aft(1, 0);
    mute = 1'b1;
    hold_window(300, "R12 muted lock holds");
    do_recall(0, 0, 0);
    aft_en = 1'b1;
    start_search();
    while (tune_value < 90) measure_gap(gap);
    measure_gap(gap);
    check(gap == 2, "R12 mute keeps fast sweep", gap, 2);
    mute = 1'b0;
  endtask

  task automatic t_wrap();
    int n;
    set_aft(1, 1);
    band_enable = 4'b1010;
    do_recall(250, 1, 0);
    start_search();
    n = 0;
    while (tune_value != 255 && n < 200) begin @(negedge clk); n++; end
    repeat (30) @(negedge clk);
    check(tune_value == 255 && band_sel == 1, "R10 pause holds top", int'(tune_value), 255);
    check(search_active == 1'b1, "R10 active during pause", int'(search_active), 1);
    n = 0;
    while (band_sel == 1 && n < 300) begin @(negedge clk); n++; end
    check(band_sel == 3 && tune_value == 0, "R10 next enabled band", int'(band_sel), 3);
    n = 0;
    while (band_sel == 3 && n < 4000) begin @(negedge clk); n++; end
    check(band_sel == 1 && tune_value == 0, "R10 wrap skips disabled", int'(band_sel), 1);
    band_enable = 4'b0000;
    do_recall(254, 2, 0);
    start_search();
    n = 0;
    while (tune_value != 0 && n < 500) begin @(negedge clk); n++; end
    check(band_sel == 2 && tune_value == 0, "R10 no enabled band keeps band", int'(band_sel), 2);
    band_enable = 4'hF;
  endtask

  initial begin
    t_reset();
    t_recall();
    t_fast_rates();
    t_uhf_down_ignored();
    t_approach();
    t_saturate();
    t_mute();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule